// File: doc/BRIEF.md
# Eight-Line Prioritised Interrupt Controller

This block gathers eight interrupt request lines into one interrupt output toward a processor. For each line it keeps a pending bit, an in-service bit and a mask bit. It resolves priority with a fixed order in which line 0 ranks highest. When the processor acknowledges, the block returns a vector number made from a programmable base and the index of the winning line.

Software reaches the block over a small register bus. The bus has one address bit, a write strobe and a read strobe. Address 0 takes the configuration start word and the operation commands, and it returns the pending or in-service register. Address 1 takes the rest of the configuration and, once configuration is done, the mask. A read-select latch decides which status register address 0 returns, and it keeps that choice until software changes it. Each line can be set to edge or level detection. A non-specific end-of-interrupt command retires the highest-priority service in progress. If a request disappears before the acknowledge, the acknowledge produces the vector of line 7. A configuration bit drives a master/slave role output for a cascaded pair.

Top module: `irq_hub8`

## Requirements
- R1: After reset, `int_o`, `vec_valid_o` and `slave_o` are 0, and a read of address 1 returns 0xFF (all lines masked). `int_o` stays 0 until configuration is complete.
- R2: A write to address 0 with bit 4 set starts configuration. Its bit 3 sets `slave_o`, and it clears the mask to 0x00, clears all in-service bits and selects the pending register for reads. The next write to address 1 sets the vector base to bits 7..3. The write to address 1 after that sets the trigger mode per line (bit n = 1 means line n is level-triggered) and completes configuration.
- R3: After configuration, a write to address 1 sets the mask, and a read of address 1 returns it. A masked line never raises `int_o`.
- R4: An edge-triggered line becomes pending one clock after its input rises. It stops being pending when the input falls or when the line is acknowledged. An input held high does not request again after its acknowledge.
- R5: A level-triggered line is pending exactly while its input is high, so it requests again after its end-of-interrupt if the input is still high.
- R6: `int_o` is 1 only when some line is unmasked and pending, and its index is lower than the index of every in-service line.
- R7: A one-cycle `inta_i` while `int_o` is 1 sets the in-service bit of the winning line (the lowest unmasked pending index). In the next cycle it drives `vec_o` = base*8 + index with `vec_valid_o` = 1 for one cycle.
- R8: An `inta_i` while `int_o` is 0 is spurious. It returns `vec_o` = base*8 + 7 and leaves the in-service register unchanged.
- R9: A write to address 0 with bit 4 = 0 and bit 3 = 1 selects what address 0 returns: bit 0 = 0 gives pending, bit 0 = 1 gives in-service. The choice persists across any number of reads.
- R10: A write to address 0 with bit 4 = 0, bit 3 = 0 and bit 5 = 1 is a non-specific end-of-interrupt: it clears the lowest-index set in-service bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 8 | Interrupt request lines, index 0 highest priority |
| addr_i | input | 1 | Register address: 0 command/status, 1 configuration/mask |
| wr_i | input | 1 | Write strobe, sampled on the clock edge |
| rd_i | input | 1 | Read strobe; `rdata_o` is 0 while low |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data |
| int_o | output | 1 | Interrupt request toward the processor |
| inta_i | input | 1 | Acknowledge pulse from the processor |
| vec_o | output | 8 | Vector returned for the last acknowledge |
| vec_valid_o | output | 1 | One-cycle flag: `vec_o` is fresh |
| slave_o | output | 1 | Cascade role: 1 slave, 0 master |

## Verification
Every cycle, the assertions check these rules. A line is pending only if its input was high in the cycle before. `int_o` never rises without an unmasked pending line, and its winner is never already in service. A full mask keeps the output low. An acknowledge adds exactly one in-service bit, or none when it is spurious. An end-of-interrupt removes exactly one. The read-select latch changes only on a command write.

The bench scenarios show the exact vector values, nested priority with two lines in service and the lowest-index retirement order. They also show an edge input held high after its acknowledge, a level input requesting again, a request withdrawn before the acknowledge, and a read-select choice that persists over repeated reads.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  localparam int LINES = 8;
  localparam int IDXW  = $clog2(LINES);
  localparam int BUSW  = 8;
  localparam int BASEW = BUSW - IDXW;

  typedef logic [LINES-1:0] lines_t;
  typedef logic [IDXW-1:0]  idx_t;
  typedef enum logic [1:0] {CFG_IDLE, CFG_BASE, CFG_TRIG} cfg_st_e;

  // index of the highest-priority (lowest-index) set bit; LINES-1 when empty
  function automatic idx_t top_line(lines_t v);
    idx_t r;
    r = idx_t'(LINES - 1);
    for (int i = LINES - 1; i >= 0; i--)
      if (v[i]) r = idx_t'(i);
    return r;
  endfunction

  // lines that rank strictly above every in-service line
  function automatic lines_t above_of(lines_t isr);
    lines_t m;
    m = '1;
    for (int i = LINES - 1; i >= 0; i--)
      if (isr[i]) m = lines_t'((1 << i) - 1);
    return m;
  endfunction

  // isolate the lowest set bit
  function automatic lines_t lowest_bit(lines_t v);
    return v & (~v + lines_t'(1));
  endfunction

  function automatic lines_t onehot(idx_t i);
    return lines_t'(1) << i;
  endfunction

  function automatic logic [BUSW-1:0] make_vec(logic [BASEW-1:0] base, idx_t idx);
    return {base, idx};
  endfunction
endpackage

// File: rtl/irq_pend_detect.sv
module irq_pend_detect
  import irq_hub_pkg::*;
#(
  parameter int N = LINES
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] level_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] req_q;
  logic [N-1:0] rise;
  logic [N-1:0] nxt;

  assign rise = req_i & ~req_q;

  for (genvar g = 0; g < N; g++) begin : g_line
    // level: follow the input; edge: latch a rise, drop on low input or acknowledge
    assign nxt[g] = level_i[g] ? req_i[g]
                               : (req_i[g] & (pend_o[g] | rise[g]) & ~clr_i[g]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= '0;
      pend_o <= '0;
    end else begin
      req_q  <= req_i;
      pend_o <= nxt;
    end
  end

  // R4/R5: nothing is pending unless its input was high in the previous cycle
  p_pend_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_o & ~$past(req_i)) == '0));

  // R4: an edge line turns pending only on a detected rise
  p_edge_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_o & ~$past(pend_o) & ~$past(level_i) & ~$past(rise)) == '0));
endmodule

// File: rtl/irq_prio_resolve.sv
module irq_prio_resolve
  import irq_hub_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   en_i,
  input  lines_t pend_i,
  input  lines_t mask_i,
  input  lines_t isr_i,
  output logic   int_o,
  output idx_t   win_o
);
  lines_t cand;

  always_comb begin
    cand  = pend_i & ~mask_i & above_of(isr_i);
    int_o = en_i & (|cand);
    win_o = top_line(cand);
  end

  // R6: the output needs an unmasked pending line
  p_int_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    int_o |-> ((pend_i & ~mask_i) != '0));

  // R6: the chosen line is never one already in service
  p_win_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
    int_o |-> !isr_i[win_o]);
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_hub_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_i,
  input  logic              wr_i,
  input  logic [BUSW-1:0]   wdata_i,
  output logic              ready_o,
  output logic [BASEW-1:0]  base_o,
  output lines_t            level_o,
  output lines_t            mask_o,
  output logic              rsel_o,
  output logic              slave_o,
  output logic              start_o,
  output logic              eoi_o
);
  cfg_st_e st;
  logic    cmd_wr;
  logic    sel_wr;

  assign start_o = wr_i & ~addr_i & wdata_i[4];
  assign cmd_wr  = wr_i & ~addr_i & ~wdata_i[4];
  assign sel_wr  = cmd_wr & wdata_i[3];
  assign eoi_o   = cmd_wr & ~wdata_i[3] & wdata_i[5];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= CFG_IDLE;
      ready_o <= 1'b0;
      base_o  <= '0;
      level_o <= '0;
      mask_o  <= '1;
      rsel_o  <= 1'b0;
      slave_o <= 1'b0;
    end else if (start_o) begin
      st      <= CFG_BASE;
      ready_o <= 1'b0;
      slave_o <= wdata_i[3];
      mask_o  <= '0;
      rsel_o  <= 1'b0;
    end else if (wr_i && addr_i) begin
      unique case (st)
        CFG_BASE: begin
          base_o <= wdata_i[BUSW-1:IDXW];
          st     <= CFG_TRIG;
        end
        CFG_TRIG: begin
          level_o <= wdata_i[LINES-1:0];
          st      <= CFG_IDLE;
          ready_o <= 1'b1;
        end
        default: if (ready_o) mask_o <= wdata_i[LINES-1:0];
      endcase
    end else if (sel_wr) begin
      rsel_o <= wdata_i[0];
    end
  end

  // R9: the read-select latch moves only on a command-address write
  p_rsel_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_i && !addr_i) |=> $stable(rsel_o));

  // R2: configuration completes only out of the trigger-mode step
  p_cfg_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_o) |-> ($past(st) == CFG_TRIG));
endmodule

// File: rtl/irq_hub8.sv
module irq_hub8
  import irq_hub_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] req_i,
  input  logic       addr_i,
  input  logic       wr_i,
  input  logic       rd_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       int_o,
  input  logic       inta_i,
  output logic [7:0] vec_o,
  output logic       vec_valid_o,
  output logic       slave_o
);
  logic             ready;
  logic [BASEW-1:0] base;
  lines_t           level;
  lines_t           mask;
  logic             rsel;
  logic             start;
  logic             eoi;
  lines_t           pend;
  lines_t           isr;
  lines_t           ack_clr;
  idx_t             win;
  logic             ack_real;
  logic             ack_spur;

  irq_cfg_regs u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr_i  (addr_i),
    .wr_i    (wr_i),
    .wdata_i (wdata_i),
    .ready_o (ready),
    .base_o  (base),
    .level_o (level),
    .mask_o  (mask),
    .rsel_o  (rsel),
    .slave_o (slave_o),
    .start_o (start),
    .eoi_o   (eoi)
  );

  irq_pend_detect #(.N(LINES)) u_pend (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (req_i),
    .level_i (level),
    .clr_i   (ack_clr),
    .pend_o  (pend)
  );

  irq_prio_resolve u_prio (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (ready),
    .pend_i (pend),
    .mask_i (mask),
    .isr_i  (isr),
    .int_o  (int_o),
    .win_o  (win)
  );

  assign ack_real = inta_i & int_o;
  assign ack_spur = inta_i & ~int_o;
  assign ack_clr  = ack_real ? onehot(win) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr         <= '0;
      vec_o       <= '0;
      vec_valid_o <= 1'b0;
    end else begin
      if (start)
        isr <= '0;
      else
        isr <= (eoi ? (isr & ~lowest_bit(isr)) : isr) | ack_clr;
      vec_valid_o <= inta_i;
      if (inta_i)
        vec_o <= make_vec(base, ack_real ? win : idx_t'(LINES - 1));
    end
  end

  always_comb begin
    if (!rd_i)       rdata_o = '0;
    else if (addr_i) rdata_o = mask;
    else             rdata_o = rsel ? isr : pend;
  end

  // R7: a real acknowledge adds exactly one in-service bit
  p_ack_sets_isr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_real && !eoi && !start) |=> ($countones(isr) == $past($countones(isr)) + 1));

  // R8: a spurious acknowledge leaves the in-service register alone
  p_spur_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_spur && !eoi && !start) |=> (isr == $past(isr)));

  // R10: an end-of-interrupt removes exactly one in-service bit
  p_eoi_one_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !inta_i && !start && (isr != '0)) |=> ($countones(isr) + 1 == $past($countones(isr))));

  // R3: with every line masked the output stays low
  p_mask_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '1) |-> !int_o);
endmodule

// File: tb/sim_irq_hub8.sv
module sim_irq_hub8;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req_i = '0;
  logic       addr_i = 1'b0;
  logic       wr_i = 1'b0;
  logic       rd_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       int_o;
  logic       inta_i = 1'b0;
  logic [7:0] vec_o;
  logic       vec_valid_o;
  logic       slave_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_hub8 u0 (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .addr_i(addr_i), .wr_i(wr_i),
    .rd_i(rd_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .int_o(int_o),
    .inta_i(inta_i), .vec_o(vec_o), .vec_valid_o(vec_valid_o), .slave_o(slave_o)
  );

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(logic a, logic [7:0] d);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk);
    wr_i = 1'b0;
  endtask

  task automatic rd(string tag, logic a, logic [7:0] exp);
    addr_i = a; rd_i = 1'b1;
    #1;
    check(tag, rdata_o, exp);
    rd_i = 1'b0;
  endtask

  task automatic line(int i, logic v);
    req_i[i] = v;
    @(negedge clk);
  endtask

  // driver: expected vector goes into the scoreboard, then the acknowledge pulse
  task automatic ack(logic [7:0] exp_vec);
    exp_q.push_back(exp_vec);
    inta_i = 1'b1;
    @(negedge clk);
    inta_i = 1'b0;
  endtask

  function automatic logic [7:0] vec_of(int base, int idx);
    return 8'(base * 8 + idx);
  endfunction

  // monitor: compare each delivered vector against the scoreboard head
  always @(negedge clk) begin
    if (rst_n && vec_valid_o) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R7: actual vector %0d expected none", vec_o);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        if (vec_o !== e) begin
          errors++;
          $display("FAIL R7/R8 vector: actual %0d expected %0d", vec_o, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 int", int_o, 0);
    check("R1 valid", vec_valid_o, 0);
    check("R1 slave", slave_o, 0);
    rd("R1 mask", 1'b1, 8'hFF);
    line(5, 1'b1);
    check("R1 int before config", int_o, 0);
    line(5, 1'b0);

    // R2 configuration: slave, base 9, lines 2 and 3 level
    wr(1'b0, 8'h18);
    wr(1'b1, 8'h48);
    wr(1'b1, 8'h0C);
    check("R2 slave", slave_o, 1);
    rd("R2 mask cleared", 1'b1, 8'h00);

    // R4 edge line 5
    line(5, 1'b1);
    check("R4 int on rise", int_o, 1);
    rd("R9 default pending", 1'b0, 8'h20);
    ack(vec_of(9, 5));
    rd("R4 pending cleared by ack", 1'b0, 8'h00);
    check("R4 held line no rerequest", int_o, 0);
    wr(1'b0, 8'h09);
    rd("R9 in-service", 1'b0, 8'h20);
    rd("R9 select persists", 1'b0, 8'h20);
    wr(1'b0, 8'h20);
    rd("R10 eoi clears", 1'b0, 8'h00);
    check("R4 held after eoi", int_o, 0);
    line(5, 1'b0);

    // R3 mask, R6 nesting, R10 order
    wr(1'b1, 8'h02);
    rd("R3 mask readback", 1'b1, 8'h02);
    line(1, 1'b1);
    check("R3 masked line", int_o, 0);
    wr(1'b1, 8'h00);
    check("R3 unmasked", int_o, 1);
    ack(vec_of(9, 1));
    line(4, 1'b1);
    check("R6 lower blocked", int_o, 0);
    line(0, 1'b1);
    check("R6 higher nests", int_o, 1);
    ack(vec_of(9, 0));
    rd("R7 two in service", 1'b0, 8'h03);
    wr(1'b0, 8'h20);
    rd("R10 lowest index first", 1'b0, 8'h02);
    check("R6 still blocked", int_o, 0);
    wr(1'b0, 8'h20);
    check("R6 released", int_o, 1);
    ack(vec_of(9, 4));
    wr(1'b0, 8'h20);
    line(0, 1'b0);
    line(1, 1'b0);
    line(4, 1'b0);

    // R5 level line 3
    line(3, 1'b1);
    check("R5 level int", int_o, 1);
    ack(vec_of(9, 3));
    check("R5 blocked while in service", int_o, 0);
    wr(1'b0, 8'h20);
    check("R5 rerequest", int_o, 1);
    wr(1'b0, 8'h08);
    rd("R5 pending follows", 1'b0, 8'h08);
    line(3, 1'b0);
    check("R5 drop", int_o, 0);

    // R8 spurious: request withdrawn before acknowledge
    line(3, 1'b1);
    check("R8 raised", int_o, 1);
    line(3, 1'b0);
    ack(vec_of(9, 7));
    wr(1'b0, 8'h09);
    rd("R8 no in-service", 1'b0, 8'h00);

    // R4 edge pending lost when input falls
    line(6, 1'b1);
    check("R4 edge6", int_o, 1);
    line(6, 1'b0);
    check("R4 fall clears", int_o, 0);

    // R2 reconfigure: master, base 4, all edge
    wr(1'b0, 8'h10);
    wr(1'b1, 8'h20);
    wr(1'b1, 8'h00);
    check("R2 master", slave_o, 0);
    rd("R2 select reset to pending", 1'b0, 8'h00);
    line(2, 1'b1);
    ack(vec_of(4, 2));
    rd("R2 line2 now edge", 1'b0, 8'h00);
    line(2, 1'b0);
    @(negedge clk);

    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R7: actual %0d vectors missing expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule